// File: doc/BRIEF.md
# Bus Drive Enable Sequencer with Double-Cycle Turn-Off

This block produces the tri-state drive enable for the shared data bus of a pipelined synchronous memory. It watches the decoded chip-select terms, the processor-side and controller-side address strobes, a write-detected flag, an asynchronous active-low output enable and an asynchronous sleep request. From these it decides, cycle by cycle, whether the bus drivers may be on. The memory array, sense path and data registers sit outside.

A read that starts from the deselected state keeps the bus dark for its first cycle, which is the cycle before its data reaches the output register. A deselect lets the drivers run on for one more cycle, so two devices sharing the bus can hand it over without a wait state. A detected write turns the drivers off at once, and they stay off until a new read is started. The sleep request passes through a synchronizer, which gives the sleep indication. After sleep is released, a quiet window follows. Any strobe or main select that arrives inside that window is ignored and raises a one-cycle error flag.

Top module: `dcd_oe_pipe`

## Requirements
- R1: The synchronous active-high reset clears the block. After reset the drive enable, the sleep indication and the error flag are all 0, and the block is deselected.
- R2: An access starts at a clock edge when the controller strobe is low, or when the processor strobe is low and the main select is 1. It is a select if both the main and the auxiliary select are 1. A read select made while the enable stage is off keeps the drive enable at 0 for the cycle after that edge. From the following cycle the drive enable follows the output enable.
- R3: After a deselect access at edge k, the drive enable keeps its previous value until edge k+1 and is 0 after edge k+1.
- R4: A read select made in the cycle after a deselect, while the enable stage is still on, causes no blank cycle. The drive enable stays 1.
- R5: While the output enable is high, the drive enable is 0 in the same cycle, with no clock edge needed.
- R6: While the write flag is 1, the drive enable is 0 in the same cycle. Once a write is seen, the drive enable stays 0 until a later read select, including through a deselect.
- R7: A processor strobe seen while the main select is 0 is ignored.
- R8: The sleep indication rises on the second clock edge after the sleep request is set, and falls on the second edge after it is cleared. The drive enable is 0 from the moment the request is set until the quiet window ends.
- R9: While the sleep indication is 1, and during the two-cycle quiet window after it falls, strobes start no access and the enable state is unchanged.
- R10: At each of the two edges that follow the fall of the sleep indication, a low strobe or a main select of 1 sets the error flag for the cycle after that edge. Otherwise the flag is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| cs_main | input | 1 | Registered main chip-select term, 1 = active; also qualifies the processor strobe |
| cs_aux | input | 1 | Registered combined auxiliary chip-select terms, 1 = active |
| strobe_p_n | input | 1 | Processor address strobe, active low |
| strobe_c_n | input | 1 | Controller address strobe, active low |
| write_det | input | 1 | Write cycle detected in this cycle, active high |
| oe_n | input | 1 | Asynchronous output enable, active low |
| sleep_req | input | 1 | Asynchronous sleep request, active high |
| bus_drive_en | output | 1 | Data-bus driver enable, 1 = drive |
| sleep_state | output | 1 | Synchronized sleep indication |
| rec_err | output | 1 | Access attempted inside the post-sleep quiet window |

## Verification
The quiet window after sleep is the hardest state to reach from the ports. It exists for only two edges, and only after the sleep request has passed fully through the synchronizer in both directions. The directed stimulus first deselects the block and holds the request for two edges. It then issues a read attempt that must be ignored, releases the request, and places a controller strobe exactly on the first window edge. A read issued afterwards must show the blank cycle, which proves that the enable state did not move. A long randomized phase, with occasional sleep toggles, is compared edge by edge against a behavioural model. This also covers the runs where a deselect and a reselect fall on adjacent edges.

// File: rtl/dcd_oe_pkg.sv
package dcd_oe_pkg;

   // Decoded access request for one clock edge
   typedef struct packed {
      logic sel_start;   // access that selects the device
      logic dsel_start;  // access that deselects the device
      logic rd_start;    // selecting access that is a read
      logic activity;    // any strobe low or main select active
   } dcd_req_t;

   localparam int unsigned DCD_MIN_SYNC = 2;

endpackage

// File: rtl/dcd_access_decode.sv
module dcd_access_decode
   import dcd_oe_pkg::*;
(
   input  logic     cs_main,
   input  logic     cs_aux,
   input  logic     strobe_p_n,
   input  logic     strobe_c_n,
   input  logic     write_det,
   input  logic     hold_off,
   output dcd_req_t req
);

   logic p_ok;
   logic c_ok;
   logic start;
   logic chosen;

   always_comb begin
      // processor strobe only counts with the main select active
      p_ok   = !strobe_p_n && cs_main;
      c_ok   = !strobe_c_n;
      start  = (p_ok || c_ok) && !hold_off;
      chosen = cs_main && cs_aux;
      req.sel_start  = start && chosen;
      req.dsel_start = start && !chosen;
      req.rd_start   = start && chosen && !write_det;
      req.activity   = !strobe_p_n || !strobe_c_n || cs_main;
   end

endmodule

// File: rtl/dcd_enable_pipe.sv
module dcd_enable_pipe
   import dcd_oe_pkg::*;
(
   input  logic     clk,
   input  logic     rst,
   input  dcd_req_t req,
   input  logic     write_det,
   output logic     en_q,
   output logic     blank_q,
   output logic     wr_q
);

   logic pend_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         en_q    <= 1'b0;
         pend_q  <= 1'b0;
         blank_q <= 1'b0;
         wr_q    <= 1'b0;
      end else begin
         if (req.sel_start)   en_q <= 1'b1;
         else if (pend_q)     en_q <= 1'b0;
         pend_q  <= req.dsel_start;
         blank_q <= req.rd_start && !en_q;
         if (req.sel_start)   wr_q <= write_det;
         else                 wr_q <= wr_q | write_det;
      end
   end

   // R3: a fresh deselect leaves the enable stage untouched for one edge
   a_r3_hold_on_deselect : assert property (@(posedge clk) disable iff (rst)
      req.dsel_start && !pend_q |=> en_q == $past(en_q));

   // R3: a pending deselect turns the stage off unless reselected
   a_r3_off_after_pend : assert property (@(posedge clk) disable iff (rst)
      pend_q && !req.sel_start |=> !en_q);

   // R2: blanking never lasts more than one cycle
   a_r2_blank_single : assert property (@(posedge clk) disable iff (rst)
      blank_q |=> !blank_q);

   // R6: write hold persists until a selecting access
   a_r6_write_sticky : assert property (@(posedge clk) disable iff (rst)
      wr_q && !req.sel_start |=> wr_q);

endmodule

// File: rtl/dcd_sleep_seq.sv
module dcd_sleep_seq
   import dcd_oe_pkg::*;
#(
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned REC_CYCLES  = 2,
   parameter bit          ERR_STICKY  = 1'b0
)(
   input  logic clk,
   input  logic rst,
   input  logic sleep_req,
   input  logic activity,
   output logic sleep_state,
   output logic quiet_win,
   output logic busy,
   output logic rec_err
);

   localparam int unsigned CW = $clog2(REC_CYCLES + 1);
   localparam logic [CW-1:0] CNT_LOAD = CW'(REC_CYCLES);

   logic [SYNC_STAGES-1:0] chain;
   logic [CW-1:0]          cnt_q;
   logic                   exiting;
   logic                   viol;

   generate
      if (SYNC_STAGES < DCD_MIN_SYNC) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
      if (REC_CYCLES < 1) begin : g_bad_rec
         $error("REC_CYCLES must be at least 1");
      end
      for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_sync
         if (g == 0) begin : g_first
            always_ff @(posedge clk) begin
               if (rst) chain[0] <= 1'b0;
               else     chain[0] <= sleep_req;
            end
         end else begin : g_next
            always_ff @(posedge clk) begin
               if (rst) chain[g] <= 1'b0;
               else     chain[g] <= chain[g-1];
            end
         end
      end
   endgenerate

   assign sleep_state = chain[SYNC_STAGES-1];
   assign exiting     = chain[SYNC_STAGES-1] && !chain[SYNC_STAGES-2];
   assign quiet_win   = (cnt_q != '0);
   assign busy        = sleep_req || (|chain) || quiet_win;
   assign viol        = quiet_win && activity;

   always_ff @(posedge clk) begin
      if (rst)               cnt_q <= '0;
      else if (exiting)      cnt_q <= CNT_LOAD;
      else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
   end

   generate
      if (ERR_STICKY) begin : g_err_sticky
         always_ff @(posedge clk) begin
            if (rst) rec_err <= 1'b0;
            else     rec_err <= rec_err | viol;
         end
      end else begin : g_err_pulse
         always_ff @(posedge clk) begin
            if (rst) rec_err <= 1'b0;
            else     rec_err <= viol;
         end
         // R10: a pulse only follows an edge inside the window
         a_r10_err_in_window : assert property (@(posedge clk) disable iff (rst)
            rec_err |-> $past(quiet_win));
      end
   endgenerate

   // R8: the window opens on the edge where sleep indication drops
   a_r8_window_after_exit : assert property (@(posedge clk) disable iff (rst)
      $fell(sleep_state) |-> quiet_win);

endmodule

// File: rtl/dcd_oe_pipe.sv
module dcd_oe_pipe
   import dcd_oe_pkg::*;
#(
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned REC_CYCLES  = 2,
   parameter bit          ERR_STICKY  = 1'b0
)(
   input  logic clk,
   input  logic rst,
   input  logic cs_main,
   input  logic cs_aux,
   input  logic strobe_p_n,
   input  logic strobe_c_n,
   input  logic write_det,
   input  logic oe_n,
   input  logic sleep_req,
   output logic bus_drive_en,
   output logic sleep_state,
   output logic rec_err
);

   dcd_req_t req;
   logic     en_q;
   logic     blank_q;
   logic     wr_q;
   logic     quiet_win;
   logic     busy;
   logic     hold_off;

   assign hold_off = sleep_state || quiet_win;

   dcd_access_decode u_dec (
      .cs_main    (cs_main),
      .cs_aux     (cs_aux),
      .strobe_p_n (strobe_p_n),
      .strobe_c_n (strobe_c_n),
      .write_det  (write_det),
      .hold_off   (hold_off),
      .req        (req)
   );

   dcd_enable_pipe u_pipe (
      .clk       (clk),
      .rst       (rst),
      .req       (req),
      .write_det (write_det),
      .en_q      (en_q),
      .blank_q   (blank_q),
      .wr_q      (wr_q)
   );

   dcd_sleep_seq #(
      .SYNC_STAGES (SYNC_STAGES),
      .REC_CYCLES  (REC_CYCLES),
      .ERR_STICKY  (ERR_STICKY)
   ) u_sleep (
      .clk         (clk),
      .rst         (rst),
      .sleep_req   (sleep_req),
      .activity    (req.activity),
      .sleep_state (sleep_state),
      .quiet_win   (quiet_win),
      .busy        (busy),
      .rec_err     (rec_err)
   );

   assign bus_drive_en = en_q && !blank_q && !wr_q && !write_det
                         && !busy && !oe_n;

   // R2: the cycle in which the enable stage first turns on is dark
   a_r2_first_cycle_dark : assert property (@(posedge clk) disable iff (rst)
      $rose(en_q) |-> !bus_drive_en);

   // R9: a settled sleep freezes the enable stage
   a_r9_sleep_frozen : assert property (@(posedge clk) disable iff (rst)
      sleep_state && $past(sleep_state) |=> $stable(en_q));

endmodule

// File: tb/dcd_oe_pipe_test.sv
module dcd_oe_pipe_test;

   localparam int CLK_P = 10;
   localparam int REC   = 2;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic cs_main = 1'b0, cs_aux = 1'b0, strobe_p_n = 1'b1, strobe_c_n = 1'b1;
   logic write_det = 1'b0, oe_n = 1'b0, sleep_req = 1'b0;
   logic bus_drive_en, sleep_state, rec_err;

   int    n_chk  = 0;
   int    n_fail = 0;
   bit    done   = 0;
   string cur_req = "R1";

   // behavioural model state
   int m_en = 0, m_pend = 0, m_blank = 0, m_wr = 0;
   int m_sq[$] = '{0, 0};   // synchronizer contents, index 0 newest
   int m_cnt = 0, m_err = 0;

   always #(CLK_P/2) clk = ~clk;

   dcd_oe_pipe uut (
      .clk(clk), .rst(rst), .cs_main(cs_main), .cs_aux(cs_aux),
      .strobe_p_n(strobe_p_n), .strobe_c_n(strobe_c_n),
      .write_det(write_det), .oe_n(oe_n), .sleep_req(sleep_req),
      .bus_drive_en(bus_drive_en), .sleep_state(sleep_state), .rec_err(rec_err)
   );

   task automatic chk(input string req, input string what, input logic act, input logic exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %b expected %b at %0t", req, what, act, exp, $time);
      end
   endtask

   function automatic logic model_drive();
      int gate_off;
      gate_off = sleep_req || m_sq[0] || m_sq[1] || (m_cnt != 0);
      return (m_en && !m_blank && !m_wr && !write_det && !gate_off && !oe_n);
   endfunction

   always @(posedge clk) begin
      if (rst) begin
         m_en = 0; m_pend = 0; m_blank = 0; m_wr = 0;
         m_sq = '{0, 0}; m_cnt = 0; m_err = 0;
      end else begin
         int gate, start, chosen, sel, act, n_en, n_cnt;
         gate   = m_sq[1] || (m_cnt != 0);
         start  = !gate && ((!strobe_p_n && cs_main) || !strobe_c_n);
         chosen = cs_main && cs_aux;
         sel    = start && chosen;
         act    = !strobe_p_n || !strobe_c_n || cs_main;
         m_err  = (m_cnt != 0) && act;
         n_en   = sel ? 1 : (m_pend ? 0 : m_en);
         m_blank = sel && !write_det && !m_en;
         m_pend = start && !chosen;
         m_wr   = sel ? int'(write_det) : (m_wr || write_det);
         m_en   = n_en;
         if (m_sq[1] && !m_sq[0]) n_cnt = REC;
         else if (m_cnt > 0)      n_cnt = m_cnt - 1;
         else                     n_cnt = 0;
         m_cnt = n_cnt;
         m_sq.push_front(int'(sleep_req));
         void'(m_sq.pop_back());
      end
   end

   always @(negedge clk) begin
      if (!rst && !done) begin
         chk(cur_req, "drive", bus_drive_en, model_drive());
         chk(cur_req, "sleep", sleep_state, logic'(m_sq[1]));
         chk(cur_req, "err",   rec_err,     logic'(m_err));
      end
   end

   task automatic go(input logic c1, input logic c2, input logic sp, input logic sc,
                     input logic wd, input logic oe, input logic slp);
      cs_main = c1; cs_aux = c2; strobe_p_n = sp; strobe_c_n = sc;
      write_det = wd; oe_n = oe; sleep_req = slp;
      @(posedge clk);
      #(CLK_P/4);
      #1;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      finish_run();
   end

   initial begin
      repeat (3) go(0,0,1,1,0,0,0);
      rst = 1'b0;
      // R1: reset state
      cur_req = "R1";
      go(0,0,1,1,0,0,0);
      chk("R1", "drive", bus_drive_en, 1'b0);
      chk("R1", "sleep", sleep_state, 1'b0);
      chk("R1", "err", rec_err, 1'b0);
      // R2: read from deselected, first cycle blank
      cur_req = "R2";
      go(1,1,1,0,0,0,0); chk("R2", "blank cycle", bus_drive_en, 1'b0);
      go(1,1,1,1,0,0,0); chk("R2", "data cycle", bus_drive_en, 1'b1);
      // R5: output enable high blocks at once
      cur_req = "R5";
      go(1,1,1,1,0,1,0); chk("R5", "oe high", bus_drive_en, 1'b0);
      go(1,1,1,1,0,0,0); chk("R5", "oe low", bus_drive_en, 1'b1);
      // R3: deselect turns off one edge late
      cur_req = "R3";
      go(0,0,1,0,0,0,0); chk("R3", "run-on", bus_drive_en, 1'b1);
      go(0,0,1,1,0,0,0); chk("R3", "off", bus_drive_en, 1'b0);
      // R4: reselect right after a deselect, no blank
      cur_req = "R4";
      go(1,1,1,0,0,0,0); go(1,1,1,1,0,0,0);
      go(0,0,1,0,0,0,0);
      go(1,1,1,0,0,0,0); chk("R4", "no blank", bus_drive_en, 1'b1);
      go(1,1,1,1,0,0,0); chk("R4", "still on", bus_drive_en, 1'b1);
      // R7: processor strobe without main select ignored
      cur_req = "R7";
      go(0,1,0,1,0,0,0); chk("R7", "ignored", bus_drive_en, 1'b1);
      go(0,1,1,1,0,0,0); chk("R7", "still on", bus_drive_en, 1'b1);
      go(1,0,0,1,0,0,0); chk("R7", "deselect run-on", bus_drive_en, 1'b1);
      go(0,0,1,1,0,0,0); chk("R7", "off", bus_drive_en, 1'b0);
      // R6: writes force the bus dark until a read
      cur_req = "R6";
      go(1,1,1,0,1,0,0); chk("R6", "write start", bus_drive_en, 1'b0);
      go(1,1,1,1,0,0,0); chk("R6", "after write", bus_drive_en, 1'b0);
      go(1,1,1,0,0,0,0); chk("R6", "read after write", bus_drive_en, 1'b1);
      go(1,1,1,1,1,0,0); chk("R6", "write flag", bus_drive_en, 1'b0);
      go(1,1,1,1,0,0,0); chk("R6", "held", bus_drive_en, 1'b0);
      go(0,0,1,0,0,0,0); chk("R6", "deselect after write", bus_drive_en, 1'b0);
      go(0,0,1,1,0,0,0);
      // R8: sleep entry and exit
      cur_req = "R8";
      go(0,0,1,1,0,0,1); chk("R8", "entry edge 1", sleep_state, 1'b0);
      go(0,0,1,1,0,0,1); chk("R8", "entry edge 2", sleep_state, 1'b1);
      cur_req = "R9";
      go(1,1,1,0,0,0,1); chk("R9", "asleep dark", bus_drive_en, 1'b0);
      cur_req = "R8";
      go(0,0,1,1,0,0,0); chk("R8", "exit edge 1", sleep_state, 1'b1);
      go(0,0,1,1,0,0,0); chk("R8", "exit edge 2", sleep_state, 1'b0);
      chk("R8", "window dark", bus_drive_en, 1'b0);
      // R10: strobe in the quiet window
      cur_req = "R10";
      go(0,0,1,0,0,0,0); chk("R10", "err set", rec_err, 1'b1);
      go(0,0,1,1,0,0,0); chk("R10", "err clear", rec_err, 1'b0);
      // R9: nothing was started during sleep or window
      cur_req = "R9";
      go(0,0,1,1,0,0,0); chk("R9", "still off", bus_drive_en, 1'b0);
      go(1,1,1,0,0,0,0); chk("R9", "blank proves deselected", bus_drive_en, 1'b0);
      go(1,1,1,1,0,0,0); chk("R9", "on", bus_drive_en, 1'b1);
      // mixed random traffic against the model
      cur_req = "R2/R3/R4/R6/R8/R10 random";
      begin
         logic slp;
         slp = 1'b0;
         for (int i = 0; i < 1500; i++) begin
            if (($urandom % 40) == 0) slp = ~slp;
            go(($urandom % 4) != 0, ($urandom % 4) != 0, ($urandom % 3) != 0,
               ($urandom % 3) != 0, ($urandom % 5) == 0, ($urandom % 6) == 0, slp);
         end
      end
      go(0,0,1,1,0,0,0);
      finish_run();
   end

endmodule